// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Port

This block is the device side of the serial link of a sigma-delta converter. It acts as an SPI mode-3 slave: the serial clock idles high, the block drives its output after each falling edge and samples its input on each rising edge, most significant bit first. Every access opens with a one-byte command. The command names one of eight registers and the direction of the access, and its address fixes how many payload bits follow. The block holds the settings registers, gives read access to the latest conversion result with an optional status byte after it, and reports on its data-out line when a new result is waiting.

Results arrive from the converter core on a single-cycle valid strobe with a 24-bit value, an error flag, a missing-reference flag and a channel number. While chip select is low and nothing is being shifted out, the data-out line carries an active-low ready flag. A host that wants a stream of samples without command overhead can switch the port into a continuous-read mode and clock out each result as soon as ready falls. A run of 40 consecutive one bits on the input resynchronises the port without any pin other than the serial ones.

The serial inputs are sampled with the system clock through two register stages, so the serial clock must be several times slower than the system clock.

Top module: `sdadc_serial_port`

## Requirements
- R1: A command byte is accepted only when its bit 7 is 0; bit 6 selects read (1) or write (0), bits 5:3 hold the register address and bit 2 requests continuous read. A byte with bit 7 set changes nothing and the next byte is again taken as a command.
- R2: Addresses 1, 2, 6 and 7 are 24-bit read/write registers, address 5 is an 8-bit read/write register, address 4 reads the 8-bit identifier DEV_ID, address 0 reads the 8-bit status byte, and a write to address 0 has no payload.
- R3: A write to address 3 consumes 24 payload bits and a write to address 4 consumes 8; both leave every register unchanged and the following byte is decoded as a command.
- R4: A read of address 3 returns the latest 24-bit result; when mode register bit 20 is 1 the 8-bit status byte follows it, giving 32 bits.
- R5: The status byte holds ready (active low) at bit 7, error at bit 6, missing reference at bit 5, the XOR of the 24 result bits at bit 4, 0 at bit 3 and the channel number at bits 2:0.
- R6: With chip select high data-out is 1; with chip select low and no read payload in progress data-out shows the ready flag.
- R7: Ready goes low the cycle after a result strobe and returns high when a data read starts; a strobe in the same cycle as a read start keeps ready low.
- R8: 40 consecutive one bits on the input restore the mode register to MODE_DEF and the configuration register to CONF_DEF, leave the other registers unchanged and return the port to command decoding; 39 ones followed by a zero do not.
- R9: A data read with bit 2 set enters continuous read without a payload; then each falling edge of the serial clock while ready is low starts a result readout without a command, and the byte 0x58 on the input during the first 8 bits of such a readout returns the port to command decoding after that readout.
- R10: Data-out changes only after a falling serial-clock edge during a payload, the input is taken on rising edges, and all fields are shifted MSB first.
- R11: After the synchronous reset the registers hold MODE_DEF, CONF_DEF, OFFS_DEF, FS_DEF and GPO_DEF, ready is high and the status byte reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, doubles as active-low ready |
| conv_valid | input | 1 | One-cycle strobe of a new conversion result |
| conv_data | input | 24 | Conversion result value |
| conv_err | input | 1 | Range error flag of the result |
| conv_noref | input | 1 | Missing-reference flag of the result |
| conv_chan | input | 3 | Channel number of the result |

## Verification
The hardest state to reach is the exit from continuous read, because there no command is decoded at all and the exit byte only counts when it arrives while a result is already being shifted out. The bench enters the mode, lets two results stream out with the input held low, then pulses a third result and drives 0x58 during the first eight clocks of its readout, after which an identifier read proves command decoding is back. The serial reset threshold is pinned from both sides by sending exactly 39 ones before a zero and then a full 48-one run.

// File: rtl/sdadc_sp_pkg.sv
package sdadc_sp_pkg;

    localparam int RES_W  = 24;
    localparam int CHAN_W = 3;
    localparam int WORD_W = 32;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_CONF = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_ID   = 3'd4;
    localparam logic [2:0] A_GPO  = 3'd5;
    localparam logic [2:0] A_OFFS = 3'd6;
    localparam logic [2:0] A_FS   = 3'd7;

    localparam int         STAT_APPEND_BIT = 20;
    localparam logic [7:0] EXIT_CMD        = 8'h58;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_CONT = 2'd3
    } sp_state_e;

    typedef struct packed {
        logic       wen_n;
        logic       rd;
        logic [2:0] addr;
        logic       cont;
        logic [1:0] spare;
    } cmd_t;

    typedef struct packed {
        logic [RES_W-1:0]  value;
        logic              err;
        logic              noref;
        logic [CHAN_W-1:0] chan;
    } result_t;

    function automatic logic [LEN_W-1:0] rd_len(input logic [2:0] a, input logic app);
        case (a)
            A_STAT, A_ID, A_GPO: rd_len = LEN_W'(8);
            A_DATA:              rd_len = app ? LEN_W'(32) : LEN_W'(24);
            default:             rd_len = LEN_W'(24);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] wr_len(input logic [2:0] a);
        case (a)
            A_STAT:       wr_len = LEN_W'(0);
            A_ID, A_GPO:  wr_len = LEN_W'(8);
            default:      wr_len = LEN_W'(24);
        endcase
    endfunction

    function automatic logic writable(input logic [2:0] a);
        writable = (a == A_MODE) || (a == A_CONF) || (a == A_GPO) ||
                   (a == A_OFFS) || (a == A_FS);
    endfunction

    function automatic logic [7:0] pack_status(input logic rdy_n, input result_t r);
        pack_status = {rdy_n, r.err, r.noref, ^r.value, 1'b0, r.chan};
    endfunction

endpackage

// File: rtl/sdadc_sp_sync_edge.sv
module sdadc_sp_sync_edge #(
    parameter int RESET_ONES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic cs_s,
    output logic bit_s,
    output logic rise,
    output logic fall,
    output logic serial_rst
);
    localparam int OW = $clog2(RESET_ONES + 1);

    logic [2:0]    sclk_p;
    logic [1:0]    cs_p;
    logic [1:0]    mosi_p;
    logic [OW-1:0] ones_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= 3'b111;
            cs_p   <= 2'b11;
            mosi_p <= 2'b00;
        end else begin
            sclk_p <= {sclk_p[1:0], sclk};
            cs_p   <= {cs_p[0], cs_n};
            mosi_p <= {mosi_p[0], mosi};
        end
    end

    assign cs_s  = cs_p[1];
    assign bit_s = mosi_p[1];
    assign rise  = sclk_p[1] & ~sclk_p[2] & ~cs_s;
    assign fall  = ~sclk_p[1] & sclk_p[2] & ~cs_s;

    // Run length of consecutive ones, saturating at the threshold
    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            ones_q <= '0;
        end else if (rise) begin
            if (!bit_s)
                ones_q <= '0;
            else if (ones_q != OW'(RESET_ONES))
                ones_q <= ones_q + 1'b1;
        end
    end

    assign serial_rst = rise & bit_s & (ones_q == OW'(RESET_ONES - 1));

endmodule

// File: rtl/sdadc_sp_result.sv
module sdadc_sp_result
    import sdadc_sp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    conv_valid,
    input  result_t conv_res,
    input  logic    take,
    output result_t res_q,
    output logic    rdy_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            rdy_n <= 1'b1;
        end else begin
            if (conv_valid)
                res_q <= conv_res;
            if (conv_valid)
                rdy_n <= 1'b0;
            else if (take)
                rdy_n <= 1'b1;
        end
    end
endmodule

// File: rtl/sdadc_sp_regs.sv
module sdadc_sp_regs
    import sdadc_sp_pkg::*;
#(
    parameter logic [23:0] MODE_DEF = 24'h080060,
    parameter logic [23:0] CONF_DEF = 24'h000117,
    parameter logic [23:0] OFFS_DEF = 24'h800000,
    parameter logic [23:0] FS_DEF   = 24'h5A1C00,
    parameter logic [7:0]  GPO_DEF  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        serial_rst,
    input  logic        we,
    input  logic [2:0]  waddr,
    input  logic [23:0] wdata,
    output logic [23:0] mode_q,
    output logic [23:0] conf_q,
    output logic [23:0] offs_q,
    output logic [23:0] fs_q,
    output logic [7:0]  gpo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_DEF;
            conf_q <= CONF_DEF;
            offs_q <= OFFS_DEF;
            fs_q   <= FS_DEF;
            gpo_q  <= GPO_DEF;
        end else if (serial_rst) begin
            mode_q <= MODE_DEF;
            conf_q <= CONF_DEF;
        end else if (we) begin
            case (waddr)
                A_MODE:  mode_q <= wdata;
                A_CONF:  conf_q <= wdata;
                A_OFFS:  offs_q <= wdata;
                A_FS:    fs_q   <= wdata;
                A_GPO:   gpo_q  <= wdata[7:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdadc_serial_port.sv
module sdadc_serial_port
    import sdadc_sp_pkg::*;
#(
    parameter int          RESET_ONES = 40,
    parameter logic [7:0]  DEV_ID     = 8'hA0,
    parameter logic [23:0] MODE_DEF   = 24'h080060,
    parameter logic [23:0] CONF_DEF   = 24'h000117,
    parameter logic [23:0] OFFS_DEF   = 24'h800000,
    parameter logic [23:0] FS_DEF     = 24'h5A1C00,
    parameter logic [7:0]  GPO_DEF    = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    input  logic        conv_valid,
    input  logic [23:0] conv_data,
    input  logic        conv_err,
    input  logic        conv_noref,
    input  logic [2:0]  conv_chan
);
    logic cs_s, bit_s, rise, fall, serial_rst;
    logic take, we, rdy_n;
    result_t res_q, conv_res;
    logic [23:0] mode_q, conf_q, offs_q, fs_q;
    logic [7:0]  gpo_q;

    sp_state_e         state;
    logic [LEN_W-1:0]  bitcnt, len;
    logic [7:0]        sh8;
    logic [22:0]       wsh;
    logic [WORD_W-1:0] tx;
    logic              miso_r, cont_q;
    logic [2:0]        cmd_addr;

    cmd_t              cmd_now;
    logic              app;
    logic [7:0]        stat;
    logic [WORD_W-1:0] rd_word, data_word;
    logic              cmd_done, rd_last, wr_last;

    assign conv_res = '{value: conv_data, err: conv_err, noref: conv_noref, chan: conv_chan};

    sdadc_sp_sync_edge #(.RESET_ONES(RESET_ONES)) u_edge (
        .clk, .rst, .sclk, .cs_n, .mosi,
        .cs_s, .bit_s, .rise, .fall, .serial_rst
    );

    sdadc_sp_result u_res (
        .clk, .rst, .conv_valid, .conv_res, .take, .res_q, .rdy_n
    );

    sdadc_sp_regs #(
        .MODE_DEF(MODE_DEF), .CONF_DEF(CONF_DEF), .OFFS_DEF(OFFS_DEF),
        .FS_DEF(FS_DEF), .GPO_DEF(GPO_DEF)
    ) u_regs (
        .clk, .rst, .serial_rst, .we, .waddr(cmd_addr), .wdata({wsh, bit_s}),
        .mode_q, .conf_q, .offs_q, .fs_q, .gpo_q
    );

    // Read payload, left-aligned in a 32-bit word
    assign cmd_now   = cmd_t'({sh8[6:0], bit_s});
    assign app       = mode_q[STAT_APPEND_BIT];
    assign stat      = pack_status(rdy_n, res_q);
    assign data_word = app ? {res_q.value, stat} : {res_q.value, 8'h00};

    always_comb begin
        case (cmd_now.addr)
            A_STAT:  rd_word = {stat, 24'h0};
            A_MODE:  rd_word = {mode_q, 8'h0};
            A_CONF:  rd_word = {conf_q, 8'h0};
            A_DATA:  rd_word = data_word;
            A_ID:    rd_word = {DEV_ID, 24'h0};
            A_GPO:   rd_word = {gpo_q, 24'h0};
            A_OFFS:  rd_word = {offs_q, 8'h0};
            default: rd_word = {fs_q, 8'h0};
        endcase
    end

    assign cmd_done = rise && (state == ST_CMD) && (bitcnt == LEN_W'(7));
    assign rd_last  = rise && (state == ST_RD) && (bitcnt == len - 1'b1);
    assign wr_last  = rise && (state == ST_WR) && (bitcnt == len - 1'b1);

    assign take = (cmd_done && !cmd_now.wen_n && cmd_now.rd &&
                   cmd_now.addr == A_DATA && !cmd_now.cont) ||
                  (fall && state == ST_CONT && !rdy_n);
    assign we   = wr_last && writable(cmd_addr) && !serial_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_CMD;
            bitcnt   <= '0;
            len      <= '0;
            sh8      <= '0;
            wsh      <= '0;
            tx       <= '0;
            miso_r   <= 1'b1;
            cont_q   <= 1'b0;
            cmd_addr <= '0;
        end else if (serial_rst) begin
            state  <= ST_CMD;
            bitcnt <= '0;
            cont_q <= 1'b0;
        end else if (cs_s) begin
            bitcnt <= '0;
            state  <= cont_q ? ST_CONT : ST_CMD;
        end else begin
            case (state)
                ST_CMD: if (rise) begin
                    sh8 <= cmd_now;
                    if (cmd_done) begin
                        bitcnt   <= '0;
                        cmd_addr <= cmd_now.addr;
                        if (!cmd_now.wen_n) begin
                            if (cmd_now.rd) begin
                                if (cmd_now.addr == A_DATA && cmd_now.cont) begin
                                    cont_q <= 1'b1;
                                    state  <= ST_CONT;
                                end else begin
                                    tx    <= rd_word;
                                    len   <= rd_len(cmd_now.addr, app);
                                    state <= ST_RD;
                                end
                            end else if (wr_len(cmd_now.addr) != '0) begin
                                len   <= wr_len(cmd_now.addr);
                                state <= ST_WR;
                            end
                        end
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_WR: if (rise) begin
                    wsh <= {wsh[21:0], bit_s};
                    if (wr_last) begin
                        bitcnt <= '0;
                        state  <= ST_CMD;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_RD: begin
                    if (fall) begin
                        miso_r <= tx[WORD_W-1];
                        tx     <= tx << 1;
                    end
                    if (rise) begin
                        if (bitcnt < LEN_W'(8))
                            sh8 <= cmd_now;
                        if (rd_last) begin
                            bitcnt <= '0;
                            if (cont_q && sh8 != EXIT_CMD) begin
                                state <= ST_CONT;
                            end else begin
                                cont_q <= 1'b0;
                                state  <= ST_CMD;
                            end
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                default: if (fall && !rdy_n) begin
                    miso_r <= data_word[WORD_W-1];
                    tx     <= data_word << 1;
                    len    <= rd_len(A_DATA, app);
                    bitcnt <= '0;
                    state  <= ST_RD;
                end
            endcase
        end
    end

    assign miso = cs_s ? 1'b1 : ((state == ST_RD) ? miso_r : rdy_n);

endmodule

// File: rtl/sdadc_sp_chk.sv
module sdadc_sp_chk #(
    parameter logic [23:0] MODE_DEF = 24'h080060,
    parameter logic [23:0] CONF_DEF = 24'h000117
) (
    input logic        clk,
    input logic        rst,
    input logic        cs_s,
    input logic        miso,
    input logic        conv_valid,
    input logic        take,
    input logic        rdy_n,
    input logic        serial_rst,
    input logic [23:0] mode_q,
    input logic [23:0] conf_q,
    input logic [1:0]  state,
    input logic        cont_q
);
    // R6
    cs_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        cs_s |-> miso);

    // R7
    conv_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
        conv_valid |=> !rdy_n);

    // R7
    take_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !conv_valid) |=> rdy_n);

    // R8
    serial_reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        serial_rst |=> (mode_q == MODE_DEF && conf_q == CONF_DEF));

    // R9
    cont_state_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd3) |-> cont_q);
endmodule

bind sdadc_serial_port sdadc_sp_chk #(.MODE_DEF(MODE_DEF), .CONF_DEF(CONF_DEF)) u_chk (
    .clk(clk), .rst(rst), .cs_s(cs_s), .miso(miso), .conv_valid(conv_valid),
    .take(take), .rdy_n(rdy_n), .serial_rst(serial_rst), .mode_q(mode_q),
    .conf_q(conf_q), .state(state), .cont_q(cont_q)
);

// File: tb/sdadc_serial_port_tb.sv
module sdadc_serial_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic        conv_valid = 1'b0;
    logic [23:0] conv_data = '0;
    logic        conv_err = 1'b0, conv_noref = 1'b0;
    logic [2:0]  conv_chan = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdadc_serial_port u_dut (
        .clk, .rst, .sclk, .cs_n, .mosi, .miso,
        .conv_valid, .conv_data, .conv_err, .conv_noref, .conv_chan
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic o);
        @(negedge clk);
        sclk = 1'b0;
        mosi = b;
        idle(4);
        o = miso;
        sclk = 1'b1;
        idle(4);
    endtask

    task automatic xfer(input int n, input logic [31:0] din, output logic [31:0] dout);
        logic o;
        dout = '0;
        for (int i = 0; i < n; i++) begin
            bit_x(din[31-i], o);
            dout = {dout[30:0], o};
        end
        mosi = 1'b0;
    endtask

    task automatic sel(input logic v);
        @(negedge clk);
        cs_n = v;
        idle(4);
    endtask

    task automatic rd_reg(input logic [2:0] a, input int n, output logic [31:0] v);
        logic [31:0] d;
        sel(1'b0);
        xfer(8, {2'b01, a, 3'b000, 24'h0}, d);
        xfer(n, 32'h0, v);
        sel(1'b1);
    endtask

    task automatic wr_reg(input logic [2:0] a, input int n, input logic [31:0] v);
        logic [31:0] d;
        sel(1'b0);
        xfer(8, {2'b00, a, 3'b000, 24'h0}, d);
        if (n > 0) xfer(n, v << (32 - n), d);
        sel(1'b1);
    endtask

    task automatic pulse_conv(input logic [23:0] d, input logic e, input logic nr, input logic [2:0] ch);
        @(negedge clk);
        conv_valid = 1'b1; conv_data = d; conv_err = e; conv_noref = nr; conv_chan = ch;
        @(negedge clk);
        conv_valid = 1'b0;
        idle(2);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        check({31'h0, miso}, 32'h1, "R6 cs high out");
        rd_reg(3'd1, 24, v); check(v, 32'h080060, "R11 mode default");
        rd_reg(3'd2, 24, v); check(v, 32'h000117, "R11 conf default");
        rd_reg(3'd6, 24, v); check(v, 32'h800000, "R11 offset default");
        rd_reg(3'd7, 24, v); check(v, 32'h5A1C00, "R11 fullscale default");
        rd_reg(3'd5, 8, v);  check(v, 32'h00, "R11 gpo default");
        rd_reg(3'd0, 8, v);  check(v, 32'h80, "R11 status after reset");
        rd_reg(3'd4, 8, v);  check(v, 32'hA0, "R2 id value");
    endtask

    task automatic t_reg_rw();
        logic [31:0] v;
        wr_reg(3'd1, 24, 32'h0A1234); wr_reg(3'd2, 24, 32'h00F00F);
        wr_reg(3'd6, 24, 32'h7FFFF0); wr_reg(3'd7, 24, 32'h123ABC);
        wr_reg(3'd5, 8, 32'h3C);
        rd_reg(3'd1, 24, v); check(v, 32'h0A1234, "R2 R10 mode rw");
        rd_reg(3'd2, 24, v); check(v, 32'h00F00F, "R2 conf rw");
        rd_reg(3'd6, 24, v); check(v, 32'h7FFFF0, "R2 offset rw");
        rd_reg(3'd7, 24, v); check(v, 32'h123ABC, "R2 fullscale rw");
        rd_reg(3'd5, 8, v);  check(v, 32'h3C, "R2 gpo rw");
        wr_reg(3'd0, 0, 32'h0);
        rd_reg(3'd1, 24, v); check(v, 32'h0A1234, "R2 status write no payload");
    endtask

    task automatic t_wen_ignored();
        logic [31:0] v, d;
        sel(1'b0);
        xfer(8, 32'h88000000, d);
        check({31'h0, miso}, 32'h1, "R1 wen byte leaves output at ready");
        xfer(8, 32'h50000000, d);
        xfer(24, 32'h0, v);
        sel(1'b1);
        check(v, 32'h00F00F, "R1 byte after rejected byte is a command");
        rd_reg(3'd1, 24, v); check(v, 32'h0A1234, "R1 rejected write left mode");
    endtask

    task automatic t_ro_writes();
        logic [31:0] v;
        wr_reg(3'd4, 8, 32'h55);
        rd_reg(3'd4, 8, v); check(v, 32'hA0, "R3 id write ignored");
        wr_reg(3'd3, 24, 32'h123456);
        rd_reg(3'd1, 24, v); check(v, 32'h0A1234, "R3 data write framing");
        rd_reg(3'd0, 8, v);  check(v, 32'h80, "R3 data write made no result");
    endtask

    task automatic t_data_status();
        logic [31:0] v;
        wr_reg(3'd1, 24, 32'h080060);
        sel(1'b0);
        check({31'h0, miso}, 32'h1, "R6 idle ready high");
        pulse_conv(24'h3C5A96, 1'b1, 1'b0, 3'd5);
        check({31'h0, miso}, 32'h0, "R7 ready low after result");
        sel(1'b1);
        rd_reg(3'd0, 8, v); check(v, 32'h45, "R5 status with new result");
        rd_reg(3'd3, 24, v); check(v, 32'h3C5A96, "R4 R10 data read");
        rd_reg(3'd0, 8, v); check(v, 32'hC5, "R7 R5 ready high after read");
        wr_reg(3'd1, 24, 32'h180060);
        pulse_conv(24'h000001, 1'b0, 1'b1, 3'd2);
        rd_reg(3'd3, 32, v); check(v, 32'h00000132, "R4 R5 data with status");
    endtask

    task automatic t_continuous();
        logic [31:0] v, d;
        wr_reg(3'd1, 24, 32'h080060);
        sel(1'b0);
        xfer(8, 32'h5C000000, d);
        idle(4);
        check({31'h0, miso}, 32'h1, "R9 cont entry no payload");
        pulse_conv(24'h123456, 1'b0, 1'b0, 3'd1);
        check({31'h0, miso}, 32'h0, "R9 ready low in cont");
        xfer(24, 32'h0, v); check(v, 32'h123456, "R9 cont first result");
        check({31'h0, miso}, 32'h1, "R9 R7 ready high after cont read");
        pulse_conv(24'hABCDEF, 1'b0, 1'b0, 3'd1);
        xfer(24, 32'h0, v); check(v, 32'hABCDEF, "R9 cont second result");
        pulse_conv(24'h0F0F0F, 1'b0, 1'b0, 3'd1);
        xfer(24, 32'h58000000, v); check(v, 32'h0F0F0F, "R9 cont exit readout");
        xfer(8, 32'h60000000, d);
        xfer(8, 32'h0, v);
        sel(1'b1);
        check(v, 32'hA0, "R9 command mode after exit");
    endtask

    task automatic t_serial_reset();
        logic [31:0] v, d;
        wr_reg(3'd1, 24, 32'h0A1234);
        wr_reg(3'd2, 24, 32'h00F00F);
        sel(1'b0);
        xfer(32, 32'hFFFFFFFF, d);
        xfer(8, 32'hFE000000, d);
        sel(1'b1);
        rd_reg(3'd1, 24, v); check(v, 32'h0A1234, "R8 39 ones no reset");
        sel(1'b0);
        xfer(32, 32'hFFFFFFFF, d);
        xfer(16, 32'hFFFF0000, d);
        rd_reg(3'd1, 24, v); check(v, 32'h080060, "R8 mode default after 48 ones");
        rd_reg(3'd2, 24, v); check(v, 32'h000117, "R8 conf default after 48 ones");
        rd_reg(3'd6, 24, v); check(v, 32'h7FFFF0, "R8 offset kept");
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        idle(5);
        t_reset_state();
        t_reg_rw();
        t_wen_ignored();
        t_ro_writes();
        t_data_status();
        t_continuous();
        t_serial_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule